// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Unit

This block sits between a simple register bus and a serial shift engine. It buffers outgoing words in an eight-entry transmit queue and incoming words in an eight-entry receive queue, each 32 bits wide. A single data offset serves both directions: a bus write appends to the transmit queue and a bus read removes the oldest receive word. The shift engine is seen as a word stream. It takes transmit words with a valid/take pair, and it delivers received words with a one-cycle valid strobe.

Software programs a fill level for each queue and can empty either queue with a self-clearing flush bit. It reads a receive-not-empty status bit and works with a small interrupt scheme that has three sticky flags: receive level reached, receive overrun and transmit level reached. Flags are cleared by writing ones to the same offset that reports them. The interrupt line is the OR of the enabled receive flags. A global enable bit gates the serial side.

Register offsets (byte addresses): control 0x00, queue control 0x04, status 0x08, interrupt enable 0x0C, interrupt status/clear 0x10, data 0x14.

Top module: `serfifo_top`

## Requirements
- R1: After reset every register reads zero, both queues are empty, irqOut and txValid are low.
- R2: A write to offset 0x14 appends busWdata to the transmit queue. When enabled, txValid is high while the queue holds a word, and words appear on txWord oldest first, one per cycle with txTake high. A write while 8 words are held is dropped.
- R3: A read of offset 0x14 returns the oldest receive word and removes it. A read of an empty queue returns zero and changes nothing.
- R4: Status offset 0x08 bit 0 is 1 exactly while the receive queue holds at least one word.
- R5: A received word that arrives while 8 words are held is dropped and sets the sticky overrun flag at status bit 0 of offset 0x10. The held words are unchanged.
- R6: The receive threshold is at bits 3:0 of offset 0x04. A received word that raises the count to the threshold sets sticky flag bit 3 of offset 0x10. Bit 9 of offset 0x10 reads 1 while the threshold is nonzero and the count is at or above it.
- R7: The transmit threshold is at bits 11:8 of offset 0x04. A take that lowers the transmit count to the threshold sets sticky flag bit 4 of offset 0x10.
- R8: Writing offset 0x10 clears flag bits 4, 3 and 0 where the written bit is 1. Zero bits leave their flags unchanged.
- R9: Writing 1 to bit 12 (transmit) or bit 4 (receive) of offset 0x04 empties that queue in one cycle. These bits read back as 0, and the thresholds written in the same write are kept.
- R10: irqOut is high when (flag bit 3 and enable bit 3 of offset 0x0C) or (flag bit 0 and enable bit 0) holds. The transmit flag never drives it.
- R11: Bit 0 of offset 0x00 enables the serial side. While it is 0, txValid is low, txTake has no effect and received words are ignored without overrun. Bus pushes and pops still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, valid in the access cycle |
| txWord | output | 32 | Oldest transmit word |
| txValid | output | 1 | Transmit word available |
| txTake | input | 1 | Engine consumes txWord |
| rxWord | input | 32 | Received word |
| rxValid | input | 1 | Received word strobe |
| ctlEnable | output | 1 | Global enable bit |
| irqOut | output | 1 | Interrupt request |

## Verification
The embedded properties watch several things on every cycle. Each queue stays within its depth, and nothing is pushed into a full queue. A flush leaves its queue empty on the following cycle. A disabled serial side holds the queue levels still. Overrun and threshold events always leave their sticky flags set. A clear with no competing event removes the overrun flag. Only the directed scenarios can show the data itself: word order through both queues, the value dropped on overflow, read-back of thresholds after a flush, and the level flag falling when a read brings the count below the threshold.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
  parameter int DataW = 32;
  parameter int AddrW = 6;
  parameter int ThrW  = 4;

  localparam logic [AddrW-1:0] OffCtrl = AddrW'(8'h00);
  localparam logic [AddrW-1:0] OffFctl = AddrW'(8'h04);
  localparam logic [AddrW-1:0] OffStat = AddrW'(8'h08);
  localparam logic [AddrW-1:0] OffIen  = AddrW'(8'h0C);
  localparam logic [AddrW-1:0] OffIst  = AddrW'(8'h10);
  localparam logic [AddrW-1:0] OffData = AddrW'(8'h14);

  localparam int BitEn      = 0;
  localparam int BitTxFlush = 12;
  localparam int TxThrLsb   = 8;
  localparam int BitRxFlush = 4;
  localparam int RxThrLsb   = 0;
  localparam int BitRne     = 0;
  localparam int BitOvr     = 0;
  localparam int BitRxCmp   = 3;
  localparam int BitTxCmp   = 4;
  localparam int BitRxLvl   = 9;

  typedef struct packed {
    logic             txPush;
    logic             rxPop;
    logic             txFlush;
    logic             rxFlush;
    logic [DataW-1:0] wdata;
  } fifoStrobe_t;

  typedef struct packed {
    logic rxOverrun;
    logic rxHitThr;
    logic txHitThr;
    logic rxAboveThr;
    logic rxNotEmpty;
  } fifoEvent_t;
endpackage

// File: rtl/serfifo_buf.sv
module serfifo_buf #(
  parameter int Depth = 8,
  parameter int Width = 32,
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1,
  localparam int CntW = $clog2(Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [Width-1:0] pushData,
  input  logic             pop,
  output logic [Width-1:0] popData,
  output logic [CntW-1:0]  count,
  output logic             full,
  output logic             empty
);
  logic [Width-1:0] mem [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;

  function automatic logic [PtrW-1:0] nextPtr(input logic [PtrW-1:0] p);
    return (p == PtrW'(Depth - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CntW'(Depth));
  assign empty   = (count == '0);
  assign popData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2 R5
  push_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  // R3
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  // R2 R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(Depth));
endmodule

// File: rtl/serfifo_dpath.sv
module serfifo_dpath
  import serfifo_pkg::*;
#(
  parameter int Depth = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic             enable,
  input  logic [ThrW-1:0]  txThr,
  input  logic [ThrW-1:0]  rxThr,
  input  logic             txTake,
  input  logic             rxValid,
  input  logic [DataW-1:0] rxWord,
  output logic [DataW-1:0] txWord,
  output logic             txValid,
  output logic [DataW-1:0] rxHead,
  output fifoEvent_t       evt
);
  localparam int CntW = $clog2(Depth + 1);
  localparam int CmpW = (CntW > ThrW) ? CntW + 1 : ThrW + 1;

  logic [CntW-1:0] txCount, rxCount;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPushOk, txPopOk, rxPushOk, rxPopOk;

  assign txPushOk = strb.txPush & ~txFull & ~strb.txFlush;
  assign txPopOk  = txTake & enable & ~txEmpty & ~strb.txFlush;
  assign rxPushOk = rxValid & enable & ~rxFull & ~strb.rxFlush;
  assign rxPopOk  = strb.rxPop & ~rxEmpty & ~strb.rxFlush;
  assign txValid  = enable & ~txEmpty;

  serfifo_buf #(.Depth(Depth), .Width(DataW)) u_txBuf (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush),
    .push(txPushOk), .pushData(strb.wdata),
    .pop(txPopOk), .popData(txWord),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  serfifo_buf #(.Depth(Depth), .Width(DataW)) u_rxBuf (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush),
    .push(rxPushOk), .pushData(rxWord),
    .pop(rxPopOk), .popData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  always_comb begin
    evt.rxOverrun  = rxValid & enable & rxFull & ~strb.rxFlush;
    evt.rxHitThr   = rxPushOk & ~rxPopOk &
                     ((CmpW'(rxCount) + CmpW'(1)) == CmpW'(rxThr));
    evt.txHitThr   = txPopOk & ~txPushOk &
                     ((CmpW'(txCount) - CmpW'(1)) == CmpW'(txThr));
    evt.rxAboveThr = (rxThr != '0) & (CmpW'(rxCount) >= CmpW'(rxThr));
    evt.rxNotEmpty = ~rxEmpty;
  end

  // R9
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFlush |=> (txCount == '0));
  // R9
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFlush |=> (rxCount == '0));
  // R11
  tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strb.txPush && !strb.txFlush) |=> $stable(txCount));
  // R11
  rx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strb.rxPop && !strb.rxFlush) |=> $stable(rxCount));
endmodule

// File: rtl/serfifo_ctrl.sv
module serfifo_ctrl
  import serfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  input  logic [DataW-1:0] rxHead,
  input  fifoEvent_t       evt,
  output fifoStrobe_t      strb,
  output logic             enable,
  output logic [ThrW-1:0]  txThr,
  output logic [ThrW-1:0]  rxThr,
  output logic             irqOut
);
  logic wrSel, rdSel;
  logic ieRc, ieOv;
  logic rcFlag, ovFlag, tcFlag;
  logic wrCtrl, wrFctl, wrIen, wrIst;

  assign wrSel  = busSel & busWr;
  assign rdSel  = busSel & ~busWr;
  assign wrCtrl = wrSel & (busAddr == OffCtrl);
  assign wrFctl = wrSel & (busAddr == OffFctl);
  assign wrIen  = wrSel & (busAddr == OffIen);
  assign wrIst  = wrSel & (busAddr == OffIst);

  always_comb begin
    strb.txPush  = wrSel & (busAddr == OffData);
    strb.rxPop   = rdSel & (busAddr == OffData);
    strb.txFlush = wrFctl & busWdata[BitTxFlush];
    strb.rxFlush = wrFctl & busWdata[BitRxFlush];
    strb.wdata   = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      txThr  <= '0;
      rxThr  <= '0;
      ieRc   <= 1'b0;
      ieOv   <= 1'b0;
    end else begin
      if (wrCtrl) enable <= busWdata[BitEn];
      if (wrFctl) begin
        txThr <= busWdata[TxThrLsb +: ThrW];
        rxThr <= busWdata[RxThrLsb +: ThrW];
      end
      if (wrIen) begin
        ieRc <= busWdata[BitRxCmp];
        ieOv <= busWdata[BitOvr];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcFlag <= 1'b0;
      ovFlag <= 1'b0;
      tcFlag <= 1'b0;
    end else begin
      rcFlag <= evt.rxHitThr  | (rcFlag & ~(wrIst & busWdata[BitRxCmp]));
      ovFlag <= evt.rxOverrun | (ovFlag & ~(wrIst & busWdata[BitOvr]));
      tcFlag <= evt.txHitThr  | (tcFlag & ~(wrIst & busWdata[BitTxCmp]));
    end
  end

  assign irqOut = (rcFlag & ieRc) | (ovFlag & ieOv);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OffCtrl: busRdata[BitEn] = enable;
      OffFctl: begin
        busRdata[TxThrLsb +: ThrW] = txThr;
        busRdata[RxThrLsb +: ThrW] = rxThr;
      end
      OffStat: busRdata[BitRne] = evt.rxNotEmpty;
      OffIen: begin
        busRdata[BitRxCmp] = ieRc;
        busRdata[BitOvr]   = ieOv;
      end
      OffIst: begin
        busRdata[BitRxLvl] = evt.rxAboveThr;
        busRdata[BitTxCmp] = tcFlag;
        busRdata[BitRxCmp] = rcFlag;
        busRdata[BitOvr]   = ovFlag;
      end
      OffData: busRdata = rxHead;
      default: busRdata = '0;
    endcase
  end

  // R5
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxOverrun |=> ovFlag);
  // R6
  rxcmp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxHitThr |=> rcFlag);
  // R7
  txcmp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.txHitThr |=> tcFlag);
  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrIst && busWdata[BitOvr] && !evt.rxOverrun) |=> !ovFlag);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ieRc || ieOv));
endmodule

// File: rtl/serfifo_top.sv
module serfifo_top
  import serfifo_pkg::*;
#(
  parameter int Depth = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic [DataW-1:0] txWord,
  output logic             txValid,
  input  logic             txTake,
  input  logic [DataW-1:0] rxWord,
  input  logic             rxValid,
  output logic             ctlEnable,
  output logic             irqOut
);
  fifoStrobe_t      strb;
  fifoEvent_t       evt;
  logic [ThrW-1:0]  txThr, rxThr;
  logic [DataW-1:0] rxHead;

  serfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxHead(rxHead), .evt(evt), .strb(strb), .enable(ctlEnable),
    .txThr(txThr), .rxThr(rxThr), .irqOut(irqOut)
  );

  serfifo_dpath #(.Depth(Depth)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .enable(ctlEnable),
    .txThr(txThr), .rxThr(rxThr), .txTake(txTake),
    .rxValid(rxValid), .rxWord(rxWord), .txWord(txWord),
    .txValid(txValid), .rxHead(rxHead), .evt(evt)
  );
endmodule

// File: tb/serfifo_top_bench.sv
module serfifo_top_bench;
  localparam logic [5:0] ACtrl = 6'h00, AFctl = 6'h04, AStat = 6'h08,
                         AIen = 6'h0C, AIst = 6'h10, AData = 6'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busWr = 0, txTake = 0, rxValid = 0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, rxWord = '0;
  logic [31:0] busRdata, txWord;
  logic txValid, ctlEnable, irqOut;
  int nChecks = 0, nFails = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  serfifo_top u_serfifo_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txWord(txWord), .txValid(txValid), .txTake(txTake),
    .rxWord(rxWord), .rxValid(rxValid), .ctlEnable(ctlEnable),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic rxSend(input logic [31:0] w);
    @(negedge clk); rxValid = 1; rxWord = w;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic txTakeOne(output logic [31:0] w, output logic v);
    @(negedge clk); #1 w = txWord; v = txValid; txTake = 1;
    @(negedge clk); txTake = 0;
  endtask

  task automatic testReset();
    busRead(ACtrl, rd); check("R1 ctrl", rd, 0);
    busRead(AFctl, rd); check("R1 fctl", rd, 0);
    busRead(AStat, rd); check("R1 stat", rd, 0);
    busRead(AIen, rd);  check("R1 ien", rd, 0);
    busRead(AIst, rd);  check("R1 ist", rd, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    check("R1 txValid", {31'b0, txValid}, 0);
  endtask

  task automatic testTxOrder();
    logic [31:0] w; logic v;
    busWrite(ACtrl, 1);
    for (int i = 0; i < 3; i++) busWrite(AData, 32'hA0 + i);
    for (int i = 0; i < 3; i++) begin
      txTakeOne(w, v);
      check("R2 tx order", w, 32'hA0 + i);
      check("R2 tx valid", {31'b0, v}, 1);
    end
    busWrite(ACtrl, 0);
    for (int i = 0; i < 9; i++) busWrite(AData, 32'h10 + i);
    #1 check("R11 txValid low when disabled", {31'b0, txValid}, 0);
    busWrite(ACtrl, 1);
    for (int i = 0; i < 8; i++) begin
      txTakeOne(w, v);
      check("R2 drain", w, 32'h10 + i);
    end
    #1 check("R2 ninth push dropped", {31'b0, txValid}, 0);
  endtask

  task automatic testRxOrder();
    for (int i = 0; i < 3; i++) rxSend(32'hB0 + i);
    busRead(AStat, rd); check("R4 not empty", rd, 1);
    for (int i = 0; i < 3; i++) begin
      busRead(AData, rd); check("R3 rx order", rd, 32'hB0 + i);
    end
    busRead(AStat, rd); check("R4 empty", rd, 0);
    busRead(AData, rd); check("R3 empty read", rd, 0);
    busRead(AStat, rd); check("R3 empty read no change", rd, 0);
  endtask

  task automatic testOverrun();
    busWrite(AIst, 32'h19);
    busWrite(AIen, 32'h1);
    for (int i = 0; i < 9; i++) rxSend(32'hC0 + i);
    busRead(AIst, rd); check("R5 overrun flag", rd & 32'h1, 1);
    check("R10 irq on overrun", {31'b0, irqOut}, 1);
    for (int i = 0; i < 8; i++) begin
      busRead(AData, rd); check("R5 held words", rd, 32'hC0 + i);
    end
    busRead(AStat, rd); check("R5 ninth dropped", rd, 0);
    busWrite(AIst, 32'h1);
    busRead(AIst, rd); check("R8 overrun cleared", rd & 32'h1, 0);
    check("R10 irq drops", {31'b0, irqOut}, 0);
  endtask

  task automatic testRxThreshold();
    busWrite(AFctl, 32'h003);
    rxSend(32'hD0); rxSend(32'hD1);
    busRead(AIst, rd); check("R6 below threshold", rd & 32'h208, 0);
    rxSend(32'hD2);
    busRead(AIst, rd); check("R6 threshold reached", rd & 32'h208, 32'h208);
    check("R10 masked", {31'b0, irqOut}, 0);
    busWrite(AIen, 32'h9);
    check("R10 enabled", {31'b0, irqOut}, 1);
    busWrite(AIst, 32'h0);
    busRead(AIst, rd); check("R8 zero write keeps", rd & 32'h8, 32'h8);
    busWrite(AIst, 32'h8);
    busRead(AIst, rd); check("R8 rx flag cleared, level kept", rd & 32'h208, 32'h200);
    check("R10 irq after clear", {31'b0, irqOut}, 0);
    busRead(AData, rd); check("R3 rx word", rd, 32'hD0);
    busRead(AIst, rd); check("R6 level falls", rd & 32'h200, 0);
  endtask

  task automatic testTxThreshold();
    logic [31:0] w; logic v;
    busWrite(AFctl, 32'h203);
    busWrite(AIst, 32'h19);
    for (int i = 0; i < 4; i++) busWrite(AData, 32'hE0 + i);
    txTakeOne(w, v);
    busRead(AIst, rd); check("R7 above threshold", rd & 32'h10, 0);
    txTakeOne(w, v);
    busRead(AIst, rd); check("R7 tx threshold reached", rd & 32'h10, 32'h10);
    check("R10 tx flag no irq", {31'b0, irqOut}, 0);
    busWrite(AIst, 32'h10);
    busRead(AIst, rd); check("R8 tx flag cleared", rd & 32'h10, 0);
  endtask

  task automatic testFlush();
    busWrite(AFctl, 32'h1213);
    busRead(AFctl, rd); check("R9 thresholds kept, flush reads 0", rd, 32'h203);
    busRead(AStat, rd); check("R9 rx emptied", rd, 0);
    #1 check("R9 tx emptied", {31'b0, txValid}, 0);
    busRead(AData, rd); check("R9 rx read zero", rd, 0);
  endtask

  task automatic testDisabled();
    logic [31:0] w; logic v;
    busWrite(ACtrl, 0);
    for (int i = 0; i < 9; i++) rxSend(32'hF0 + i);
    busRead(AStat, rd); check("R11 rx ignored", rd, 0);
    busRead(AIst, rd); check("R11 no overrun", rd & 32'h1, 0);
    busWrite(AData, 32'h55);
    @(negedge clk); txTake = 1; @(negedge clk); txTake = 0;
    busWrite(ACtrl, 1);
    txTakeOne(w, v);
    check("R11 push kept while disabled", w, 32'h55);
    check("R11 valid after enable", {31'b0, v}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testTxOrder();
    testRxOrder();
    testOverrun();
    testRxThreshold();
    testTxThreshold();
    testFlush();
    testDisabled();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule